// File: doc/BRIEF.md
# SPI flash user-mode command tracker

This block lives inside a memory-mapped SPI flash controller and follows the byte stream that firmware pushes while the controller runs in user mode. A register write port carries updates to the control word, and the block drives the flash chip select from it. Each byte that arrives on the input stream is labelled as an opcode, an address byte or a payload byte. The block also inserts the filler bytes that a read command needs between its address and its data.

Phase tracking restarts only when chip select truly goes from inactive to active. A control write that keeps the chip selected leaves the tracking where it was, even if it changes the lane width. Payload bytes that happen to equal a known opcode therefore still pass through as data. Any deselect returns the tracker to idle at once, and the idle tracker drops incoming bytes.

Both byte interfaces use valid/ready handshakes. The input stream is accepted only when the output stream takes a byte (`in_ready` follows `out_ready`), so back-pressure flows straight through. While a filler byte is being emitted, `in_ready` stays low and the pending input byte waits. While deselected, `in_ready` is high and bytes are discarded without output.

Top module: `spi_cmd_tracker`

## Requirements
- R1: After reset `cs_n` is 1, `io_mode` is 0 and `out_valid` is 0.
- R2: A write at offset 0x10 with bits 1:0 = 2'b11 and bit 2 = 0 (user mode, active) drives `cs_n` to 0 on the next cycle, and the first byte accepted after that is tagged as an opcode (tag 0).
- R3: The tags are 0 opcode, 1 address, 2 filler and 3 payload. After opcode 0x34 or 0x12 exactly four bytes are tagged address. After 0x02, 0x0B, 0x6B or 0xEB exactly three bytes are tagged address. After 0x0C four bytes are tagged address. The bytes that follow are tagged payload.
- R4: Filler counts are one byte for 0x0B, 0x6B and 0x0C, three bytes for 0xEB and none for the other opcodes. Each filler byte appears on the output as 0xFF with tag 2 while `in_ready` is 0, and is inserted after the last address byte.
- R5: An opcode outside the R3 list has no address or filler phase: the next accepted byte is tagged payload.
- R6: A control write that keeps the chip selected updates `io_mode` from bits 31:28 on the next cycle and does not restart tracking. Later payload bytes, 0x34 among them, stay tagged payload.
- R7: A control write with bit 2 = 1 drives `cs_n` to 1 on the next cycle. While `cs_n` is 1, input bytes are accepted and produce no output. A later user-mode write restarts tracking at the opcode phase.
- R8: A control write with bits 1:0 other than 2'b11 also deselects: `cs_n` is 1 on the next cycle.
- R9: Writes to any offset other than 0x10 leave `cs_n` and `io_mode` unchanged.
- R10: While the chip is selected and `out_ready` is 0, `in_ready` is 0 and the phase does not advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register byte offset |
| wr_data | input | 32 | Register write data |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted |
| in_byte | input | 8 | Input byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream ready |
| out_byte | output | 8 | Output byte (0xFF for filler) |
| out_tag | output | 2 | Byte class: 0 opcode, 1 address, 2 filler, 3 payload |
| cs_n | output | 1 | Flash chip select, active low |
| io_mode | output | 4 | Lane mode from control bits 31:28 |

## Verification
The assertions check the cycle-level relations on every cycle: chip select following each control write, writes to other offsets having no effect, no output while deselected, filler bytes that are 0xFF and hold the input off, back-pressure blocking the input, and the lane mode tracking the last control write. What only the bench scenarios can show is the phase sequence itself. That includes the number of address and filler bytes for each opcode, the survival of payload bytes equal to 0x34 after a lane-mode write mid-transfer, and the restart of tracking after a deselect followed by a reselect.

// File: rtl/spi_trk_pkg.sv
package spi_trk_pkg;
  localparam int CNT_W = 3;

  typedef enum logic [2:0] {
    ST_OFF, ST_CMD, ST_ADDR, ST_DUMMY, ST_DATA
  } snoop_e;

  typedef enum logic [1:0] {
    TAG_CMD = 2'd0, TAG_ADDR = 2'd1, TAG_DUMMY = 2'd2, TAG_DATA = 2'd3
  } tag_e;

  typedef struct packed {
    logic [CNT_W-1:0] n_addr;
    logic [CNT_W-1:0] n_dummy;
  } op_info_t;

  // address and filler byte counts per opcode; unknown opcodes get none
  function automatic op_info_t op_lookup(input logic [7:0] op);
    op_info_t r;
    r = '0;
    case (op)
      8'h02: r.n_addr = 3'd3;
      8'h12: r.n_addr = 3'd4;
      8'h34: r.n_addr = 3'd4;
      8'h0B: begin r.n_addr = 3'd3; r.n_dummy = 3'd1; end
      8'h6B: begin r.n_addr = 3'd3; r.n_dummy = 3'd1; end
      8'h0C: begin r.n_addr = 3'd4; r.n_dummy = 3'd1; end
      8'hEB: begin r.n_addr = 3'd3; r.n_dummy = 3'd3; end
      default: r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/spi_ctl_regs.sv
module spi_ctl_regs #(
  parameter int ADDR_W = 8,
  parameter int REG_W = 32,
  parameter int MODE_W = 4,
  parameter logic [ADDR_W-1:0] CTRL_OFFSET = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  output logic              cs_n,
  output logic [MODE_W-1:0] io_mode,
  output logic              sel_start,
  output logic              sel_stop
);
  localparam int MODE_LSB = REG_W - MODE_W;

  logic              hit;
  logic              new_unsel;
  logic              unsel_q;
  logic [MODE_W-1:0] mode_q;
  logic              unused_bits;

  assign hit       = wr_en && (wr_addr == CTRL_OFFSET);
  assign new_unsel = !((wr_data[1:0] == 2'b11) && !wr_data[2]);
  // only a change of the select state counts as an edge
  assign sel_start = hit && unsel_q && !new_unsel;
  assign sel_stop  = hit && !unsel_q && new_unsel;
  assign unused_bits = ^wr_data[MODE_LSB-1:3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unsel_q <= 1'b1;
      mode_q  <= '0;
    end else if (hit) begin
      mode_q <= wr_data[REG_W-1:MODE_LSB];
      if (new_unsel != unsel_q) unsel_q <= new_unsel;
    end
  end

  assign cs_n    = unsel_q;
  assign io_mode = mode_q;
endmodule

// File: rtl/spi_snoop_fsm.sv
module spi_snoop_fsm
  import spi_trk_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_start,
  input  logic              sel_stop,
  input  logic              fire,
  input  logic [DATA_W-1:0] in_byte,
  output snoop_e            state
);
  logic [CNT_W-1:0] addr_left;
  logic [CNT_W-1:0] dum_left;
  op_info_t         info;

  assign info = op_lookup(in_byte[7:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_OFF;
      addr_left <= '0;
      dum_left  <= '0;
    end else if (sel_stop) begin
      state     <= ST_OFF;
      addr_left <= '0;
      dum_left  <= '0;
    end else if (sel_start) begin
      state     <= ST_CMD;
      addr_left <= '0;
      dum_left  <= '0;
    end else if (fire) begin
      case (state)
        ST_CMD: begin
          addr_left <= info.n_addr;
          dum_left  <= info.n_dummy;
          if (info.n_addr != '0)       state <= ST_ADDR;
          else if (info.n_dummy != '0) state <= ST_DUMMY;
          else                         state <= ST_DATA;
        end
        ST_ADDR: begin
          addr_left <= addr_left - 1'b1;
          if (addr_left == 3'd1) state <= (dum_left != '0) ? ST_DUMMY : ST_DATA;
        end
        ST_DUMMY: begin
          dum_left <= dum_left - 1'b1;
          if (dum_left == 3'd1) state <= ST_DATA;
        end
        default: state <= state;
      endcase
    end
  end
endmodule

// File: rtl/spi_byte_steer.sv
module spi_byte_steer
  import spi_trk_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] FILL = 8'hFF
) (
  input  snoop_e            state,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_byte,
  input  logic              out_ready,
  output logic              in_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_byte,
  output logic [1:0]        out_tag,
  output logic              fire
);
  always_comb begin
    out_byte  = in_byte;
    out_valid = in_valid;
    in_ready  = out_ready;
    fire      = in_valid && out_ready;
    out_tag   = TAG_DATA;
    case (state)
      ST_OFF: begin
        out_valid = 1'b0;
        in_ready  = 1'b1;
        fire      = 1'b0;
      end
      ST_CMD:  out_tag = TAG_CMD;
      ST_ADDR: out_tag = TAG_ADDR;
      ST_DUMMY: begin
        out_tag   = TAG_DUMMY;
        out_byte  = FILL;
        out_valid = 1'b1;
        in_ready  = 1'b0;
        fire      = out_ready;
      end
      default: out_tag = TAG_DATA;
    endcase
  end
endmodule

// File: rtl/spi_cmd_tracker.sv
module spi_cmd_tracker
  import spi_trk_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int REG_W = 32,
  parameter int MODE_W = 4,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFFSET = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_byte,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_byte,
  output logic [1:0]        out_tag,
  output logic              cs_n,
  output logic [MODE_W-1:0] io_mode
);
  logic   sel_start;
  logic   sel_stop;
  logic   fire;
  snoop_e state;

  spi_ctl_regs #(
    .ADDR_W(ADDR_W), .REG_W(REG_W), .MODE_W(MODE_W), .CTRL_OFFSET(CTRL_OFFSET)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cs_n(cs_n), .io_mode(io_mode),
    .sel_start(sel_start), .sel_stop(sel_stop)
  );

  spi_snoop_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sel_start(sel_start), .sel_stop(sel_stop),
    .fire(fire), .in_byte(in_byte), .state(state)
  );

  spi_byte_steer #(.DATA_W(DATA_W)) u_steer (
    .state(state), .in_valid(in_valid), .in_byte(in_byte),
    .out_ready(out_ready), .in_ready(in_ready), .out_valid(out_valid),
    .out_byte(out_byte), .out_tag(out_tag), .fire(fire)
  );
endmodule

// File: rtl/spi_trk_checks.sv
module spi_trk_checks (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [7:0]  wr_addr,
  input logic [31:0] wr_data,
  input logic        out_ready,
  input logic        in_ready,
  input logic        out_valid,
  input logic [7:0]  out_byte,
  input logic [1:0]  out_tag,
  input logic        cs_n,
  input logic [3:0]  io_mode
);
  logic hit;
  logic unused_bits;
  assign hit = wr_en && (wr_addr == 8'h10);
  assign unused_bits = ^wr_data[27:3];

  assert_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit && wr_data[1:0] == 2'b11 && !wr_data[2] |=> !cs_n);

  assert_stop_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit && wr_data[2] |=> cs_n);

  assert_idle_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !out_valid);

  assert_leave_user_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hit && wr_data[1:0] != 2'b11 |=> cs_n);

  assert_other_offset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !hit |=> $stable(cs_n) && $stable(io_mode));

  assert_fill_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_tag == 2'd2 |-> out_byte == 8'hFF && !in_ready);

  assert_backpressure_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n && !out_ready |-> !in_ready);

  assert_io_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> io_mode == $past(wr_data[31:28]));
endmodule

bind spi_cmd_tracker spi_trk_checks u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .out_ready(out_ready), .in_ready(in_ready),
  .out_valid(out_valid), .out_byte(out_byte), .out_tag(out_tag),
  .cs_n(cs_n), .io_mode(io_mode)
);

// File: tb/sim_spi_cmd_tracker.sv
module sim_spi_cmd_tracker;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_byte = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_byte;
  logic [1:0]  out_tag;
  logic        cs_n;
  logic [3:0]  io_mode;

  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;

  spi_cmd_tracker u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .out_valid(out_valid), .out_ready(out_ready),
    .out_byte(out_byte), .out_tag(out_tag), .cs_n(cs_n), .io_mode(io_mode)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void ref_info(input logic [7:0] op, output int na, output int nd);
    na = 0; nd = 0;
    if (op == 8'h34 || op == 8'h12 || op == 8'h0C) na = 4;
    if (op == 8'h02 || op == 8'h0B || op == 8'h6B || op == 8'hEB) na = 3;
    if (op == 8'h0B || op == 8'h6B || op == 8'h0C) nd = 1;
    if (op == 8'hEB) nd = 3;
  endfunction

  // all tasks enter and leave at a falling edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic push(input logic [7:0] b, input logic [1:0] tag, input string req);
    in_valid = 1'b1; in_byte = b; out_ready = 1'b1;
    #1;
    chk({req, " valid"}, out_valid, 1'b1);
    chk({req, " tag"}, out_tag, tag);
    chk({req, " byte"}, out_byte, b);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic stall(input logic [1:0] tag);
    in_valid = 1'b1; in_byte = 8'h34; out_ready = 1'b0;
    #1;
    chk("R10 in_ready low", in_ready, 1'b0);
    chk("R10 tag held", out_tag, tag);
    @(negedge clk);
    out_ready = 1'b1; in_valid = 1'b0;
  endtask

  task automatic filler();
    in_valid = 1'b1; in_byte = 8'hA5; out_ready = 1'b1;
    #1;
    chk("R4 fill valid", out_valid, 1'b1);
    chk("R4 fill tag", out_tag, 2'd2);
    chk("R4 fill byte", out_byte, 8'hFF);
    chk("R4 input held", in_ready, 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic dropped();
    in_valid = 1'b1; in_byte = 8'h34;
    #1;
    chk("R7 no output when idle", out_valid, 1'b0);
    chk("R7 idle accepts", in_ready, 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20241024));
    repeat (3) @(negedge clk);
    #1;
    chk("R1 cs_n", cs_n, 1'b1);
    chk("R1 io_mode", io_mode, 4'h0);
    chk("R1 out_valid", out_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    dropped();

    // lane-mode change in the middle of a page program
    wr(8'h10, 32'h0000_0003);
    chk("R2 select", cs_n, 1'b0);
    push(8'h34, 2'd0, "R2 opcode");
    for (int i = 0; i < 4; i++) push(8'h10 + i[7:0], 2'd1, "R3 addr");
    push(8'h55, 2'd3, "R3 payload");
    wr(8'h10, 32'h8000_0003);
    chk("R6 io_mode", io_mode, 4'h8);
    chk("R6 still selected", cs_n, 1'b0);
    push(8'hEB, 2'd3, "R6 payload");
    push(8'hD8, 2'd3, "R6 payload");
    push(8'hC1, 2'd3, "R6 payload");
    push(8'h34, 2'd3, "R6 payload 34");

    wr(8'h10, 32'h8000_0007);
    chk("R7 deselect", cs_n, 1'b1);
    dropped();
    wr(8'h10, 32'h0000_0003);
    push(8'h0B, 2'd0, "R7 restart opcode");
    for (int i = 0; i < 3; i++) push(8'h20, 2'd1, "R3 addr 0B");
    stall(2'd2);
    filler();
    stall(2'd3);
    push(8'h77, 2'd3, "R4 after fill");

    wr(8'h10, 32'h0000_0001);
    chk("R8 leave user", cs_n, 1'b1);
    wr(8'h14, 32'h4000_0003);
    chk("R9 cs_n unchanged", cs_n, 1'b1);
    chk("R9 io_mode unchanged", io_mode, 4'h0);
    wr(8'h10, 32'h0000_0003);
    wr(8'h14, 32'h0000_0004);
    chk("R9 no deselect", cs_n, 1'b0);
    push(8'h9F, 2'd0, "R5 opcode");
    push(8'h9F, 2'd3, "R5 payload");

    wr(8'h10, 32'h0000_0003);
    push(8'h9F, 2'd3, "R6 rewrite same select");
    wr(8'h10, 32'h0000_0000);

    for (int it = 0; it < 60; it++) begin
      logic [3:0] md;
      logic [7:0] op;
      int na, nd, np;
      md = 4'($urandom);
      op = 8'($urandom);
      if (it % 3 == 0) begin
        case ($urandom % 7)
          0: op = 8'h34; 1: op = 8'h0B; 2: op = 8'hEB; 3: op = 8'h02;
          4: op = 8'h6B; 5: op = 8'h0C; default: op = 8'h12;
        endcase
      end
      ref_info(op, na, nd);
      wr(8'h10, {md, 28'h000_0003});
      chk("R2 select", cs_n, 1'b0);
      push(op, 2'd0, "R2 opcode");
      for (int i = 0; i < na; i++) begin
        if ($urandom % 4 == 0) stall(2'd1);
        push(8'($urandom), 2'd1, "R3 addr");
      end
      for (int i = 0; i < nd; i++) filler();
      np = 1 + $urandom % 6;
      for (int i = 0; i < np; i++) begin
        if ($urandom % 4 == 0) begin
          md = 4'($urandom);
          wr(8'h10, {md, 28'h000_0003});
          chk("R6 io_mode", io_mode, md);
        end
        if ($urandom % 5 == 0) stall(2'd3);
        push((i == 0) ? 8'h34 : 8'($urandom), 2'd3, "R6 payload");
      end
      if (it % 2 == 0) begin
        wr(8'h10, {md, 28'h000_0007});
        chk("R7 deselect", cs_n, 1'b1);
      end else begin
        wr(8'h10, {md, 28'h000_0002});
        chk("R8 leave user", cs_n, 1'b1);
      end
      dropped();
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end
endmodule